// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Merger

This block owns a floating-point status word whose five exception bits are sticky. Execution hardware may post exception flags into the word at any time. Some of these flags are set spuriously: invalid on non-finite input, and underflow on results that are exact. When an operation is committed, the block rebuilds the word from three parts. It rolls back any invalid and underflow bits that were not already sticky after the previous committed operation. It keeps every other sticky bit. It then ORs in the flags that were computed as correct for the operation.

At the same commit the block decides whether the operation must trap. A trap is requested when the global software trap enable is on and at least one of the operation's correct flags has its own enable set. The trap request is registered on the same edge as the new word and holds until the next commit.

The trap request comes from a two-state machine:
- In TS_CALM no trap is requested. In TS_RAISED a trap is requested.
- A commit that hits an enabled exception moves the machine to TS_RAISED, from either state.
- A commit that hits no enabled exception moves the machine to TS_CALM, from either state.
- Without a commit the machine stays where it is.

Top module: `fpx_sticky_status`

## Requirements
- R1: After reset the status word is all zeros and the trap request is low.
- R2: On a cycle with hw_post high and commit low, the hardware flags are ORed into the word at their parameter positions by the next edge. Without a commit, no bit of the word is ever cleared. Flag vectors use the encoding bit0 inexact, bit1 divide-by-zero, bit2 underflow, bit3 overflow, bit4 invalid.
- R3: At a commit, an invalid bit that is set in the live word but was not set in the word saved at the previous commit is cleared, unless the current flags carry invalid.
- R4: At a commit, an underflow bit that is set in the live word but not in the saved word is cleared, unless the current flags carry underflow.
- R5: Invalid and underflow bits that were set in the word saved at the previous commit survive the next commit.
- R6: Overflow, divide-by-zero and inexact bits, once set, are never cleared by a commit.
- R7: At a commit, every current flag is ORed into the word at its position.
- R8: The trap request is registered on the commit edge. It is high when the global enable is on and the current flags AND the per-exception enables are non-zero. It holds its value until the next commit.
- R9: No trap is requested when the global enable is off. No trap is requested for an exception whose own enable bit is off.
- R10: Each commit saves the new word as the reference for the next commit. A spurious underflow posted after a commit that set invalid is rolled back at the following commit, and that invalid is kept.
- R11: When hw_post and commit are high in the same cycle, the posted flags take part in that commit. A posted invalid or underflow that was not already sticky is rolled back there, and a posted overflow, divide-by-zero or inexact is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit | input | 1 | One-cycle strobe that completes an operation |
| hw_post | input | 1 | Strobe that posts the hardware-produced flags |
| hw_flags | input | 5 | Flags as raised by the hardware (R2 encoding) |
| cur_flags | input | 5 | Flags computed as correct for the committed operation |
| trap_en | input | 5 | Per-exception trap enables (R2 encoding) |
| sw_trap_en | input | 1 | Global software trap enable |
| status_word | output | W | Live status word |
| trap_req | output | 1 | Registered trap request |

## Verification
The bench builds the block with a 12-bit word and scatters the five flags across it in an order unlike the flag-vector encoding: overflow at bit 0, divide-by-zero at bit 3, underflow at bit 7, inexact at bit 9 and invalid at bit 11. With this layout, a mapping error that swaps, drops or shifts a flag shows up as a wrong word. The layout also keeps the rollback mask apart from the sticky-keep mask, so a fault in either mask lands on a distinct bit. Spurious flags are posted both between commits and in the same cycle as a commit, which exercises the saved-word reference and the same-cycle merge.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int NFLAG = 5;

    // flag-vector encoding shared by all ports
    typedef enum logic [2:0] {
        FX_INX = 3'd0,
        FX_DZ  = 3'd1,
        FX_UND = 3'd2,
        FX_OVF = 3'd3,
        FX_INV = 3'd4
    } fx_idx_e;

    typedef logic [NFLAG-1:0] fx_vec_t;

    // flags that may be rolled back at commit
    localparam fx_vec_t FX_GUARD = fx_vec_t'((1 << FX_INV) | (1 << FX_UND));

    typedef enum logic {
        TS_CALM   = 1'b0,
        TS_RAISED = 1'b1
    } trap_state_e;
endpackage

// File: rtl/fpx_flag_map.sv
module fpx_flag_map
    import fpx_pkg::*;
#(
    parameter int W     = 32,
    parameter int P_INX = 0,
    parameter int P_DZ  = 1,
    parameter int P_UND = 2,
    parameter int P_OVF = 3,
    parameter int P_INV = 4
) (
    input  fx_vec_t        flags,
    output logic [W-1:0]   word
);
    logic [W-1:0] lane [NFLAG];

    for (genvar g = 0; g < NFLAG; g++) begin : g_lane
        localparam int P = (g == FX_INX) ? P_INX :
                           (g == FX_DZ)  ? P_DZ  :
                           (g == FX_UND) ? P_UND :
                           (g == FX_OVF) ? P_OVF : P_INV;
        assign lane[g] = flags[g] ? (W'(1) << P) : '0;
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < NFLAG; i++) begin
            word = word | lane[i];
        end
    end
endmodule

// File: rtl/fpx_merge_core.sv
module fpx_merge_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] live_word,
    input  logic [W-1:0] saved_word,
    input  logic [W-1:0] hw_word,
    input  logic         hw_post,
    input  logic [W-1:0] cur_word,
    input  logic [W-1:0] guard_mask,
    output logic [W-1:0] posted_word,
    output logic [W-1:0] commit_word
);
    logic [W-1:0] keep_mask;

    always_comb begin
        posted_word = hw_post ? (live_word | hw_word) : live_word;
        // guarded bits survive only if sticky in the saved reference
        keep_mask   = ~guard_mask | saved_word;
        commit_word = (posted_word & keep_mask) | cur_word;
    end
endmodule

// File: rtl/fpx_trap_fsm.sv
module fpx_trap_fsm
    import fpx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    commit,
    input  fx_vec_t cur_flags,
    input  fx_vec_t trap_en,
    input  logic    sw_trap_en,
    output logic    trap_req
);
    trap_state_e state_q, state_d;
    logic        hit;

    assign hit = sw_trap_en && (|(cur_flags & trap_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_CALM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        trap_req = 1'b0;
        unique case (state_q)
            TS_CALM: begin
                trap_req = 1'b0;
                if (commit && hit) state_d = TS_RAISED;
            end
            TS_RAISED: begin
                trap_req = 1'b1;
                if (commit && !hit) state_d = TS_CALM;
            end
        endcase
    end
endmodule

// File: rtl/fpx_sticky_status.sv
module fpx_sticky_status
    import fpx_pkg::*;
#(
    parameter int W     = 32,
    parameter int P_INX = 0,
    parameter int P_DZ  = 1,
    parameter int P_UND = 2,
    parameter int P_OVF = 3,
    parameter int P_INV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic         hw_post,
    input  logic [4:0]   hw_flags,
    input  logic [4:0]   cur_flags,
    input  logic [4:0]   trap_en,
    input  logic         sw_trap_en,
    output logic [W-1:0] status_word,
    output logic         trap_req
);
    logic [W-1:0] live_q, saved_q;
    logic [W-1:0] hw_word, cur_word, guard_mask;
    logic [W-1:0] posted_word, commit_word;

    fpx_flag_map #(.W(W), .P_INX(P_INX), .P_DZ(P_DZ), .P_UND(P_UND),
                   .P_OVF(P_OVF), .P_INV(P_INV))
        u_map_hw (.flags(hw_flags), .word(hw_word));

    fpx_flag_map #(.W(W), .P_INX(P_INX), .P_DZ(P_DZ), .P_UND(P_UND),
                   .P_OVF(P_OVF), .P_INV(P_INV))
        u_map_cur (.flags(cur_flags), .word(cur_word));

    fpx_flag_map #(.W(W), .P_INX(P_INX), .P_DZ(P_DZ), .P_UND(P_UND),
                   .P_OVF(P_OVF), .P_INV(P_INV))
        u_map_guard (.flags(FX_GUARD), .word(guard_mask));

    fpx_merge_core #(.W(W)) u_merge (
        .live_word   (live_q),
        .saved_word  (saved_q),
        .hw_word     (hw_word),
        .hw_post     (hw_post),
        .cur_word    (cur_word),
        .guard_mask  (guard_mask),
        .posted_word (posted_word),
        .commit_word (commit_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q  <= '0;
            saved_q <= '0;
        end else if (commit) begin
            live_q  <= commit_word;
            saved_q <= commit_word;
        end else begin
            live_q  <= posted_word;
        end
    end

    fpx_trap_fsm u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .cur_flags  (cur_flags),
        .trap_en    (trap_en),
        .sw_trap_en (sw_trap_en),
        .trap_req   (trap_req)
    );

    assign status_word = live_q;
endmodule

// File: rtl/fpx_sticky_status_chk.sv
module fpx_sticky_status_chk #(
    parameter int W     = 32,
    parameter int P_INX = 0,
    parameter int P_DZ  = 1,
    parameter int P_UND = 2,
    parameter int P_OVF = 3,
    parameter int P_INV = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         commit,
    input logic [4:0]   cur_flags,
    input logic [4:0]   trap_en,
    input logic         sw_trap_en,
    input logic [W-1:0] status_word,
    input logic         trap_req
);
    localparam int POS [5] = '{P_INX, P_DZ, P_UND, P_OVF, P_INV};

    function automatic logic [W-1:0] place(input logic [4:0] f);
        logic [W-1:0] w;
        w = '0;
        for (int i = 0; i < 5; i++) begin
            if (f[i]) w[POS[i]] = 1'b1;
        end
        return w;
    endfunction

    localparam logic [W-1:0] KEEP_MASK = place(5'b01011);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (status_word == '0) && !trap_req);

    a_r2_no_clear_between: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ((status_word & $past(status_word)) == $past(status_word)));

    a_r6_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((status_word & $past(status_word) & KEEP_MASK)
                    == ($past(status_word) & KEEP_MASK)));

    a_r7_current_in: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((status_word & place($past(cur_flags))) == place($past(cur_flags))));

    a_r8_trap_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sw_trap_en && (|(cur_flags & trap_en))) |=> trap_req);

    a_r8_trap_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(trap_req));

    a_r9_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !sw_trap_en) |=> !trap_req);
endmodule

bind fpx_sticky_status fpx_sticky_status_chk #(
    .W(W), .P_INX(P_INX), .P_DZ(P_DZ), .P_UND(P_UND), .P_OVF(P_OVF), .P_INV(P_INV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .cur_flags   (cur_flags),
    .trap_en     (trap_en),
    .sw_trap_en  (sw_trap_en),
    .status_word (status_word),
    .trap_req    (trap_req)
);

// File: tb/fpx_sticky_status_tb.sv
module fpx_sticky_status_tb;
    localparam int W     = 12;
    localparam int P_INX = 9;
    localparam int P_DZ  = 3;
    localparam int P_UND = 7;
    localparam int P_OVF = 0;
    localparam int P_INV = 11;
    localparam int POS [5] = '{P_INX, P_DZ, P_UND, P_OVF, P_INV};

    localparam logic [4:0] F_INX = 5'b00001;
    localparam logic [4:0] F_DZ  = 5'b00010;
    localparam logic [4:0] F_UND = 5'b00100;
    localparam logic [4:0] F_OVF = 5'b01000;
    localparam logic [4:0] F_INV = 5'b10000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         commit = 1'b0, hw_post = 1'b0, sw_trap_en = 1'b0;
    logic [4:0]   hw_flags = '0, cur_flags = '0, trap_en = '0;
    logic [W-1:0] status_word;
    logic         trap_req;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    logic [W-1:0] exp_live, exp_saved;
    logic         exp_trap;

    always #2 clk = ~clk;

    fpx_sticky_status #(.W(W), .P_INX(P_INX), .P_DZ(P_DZ), .P_UND(P_UND),
                        .P_OVF(P_OVF), .P_INV(P_INV)) u_dut (
        .clk(clk), .rst_n(rst_n), .commit(commit), .hw_post(hw_post),
        .hw_flags(hw_flags), .cur_flags(cur_flags), .trap_en(trap_en),
        .sw_trap_en(sw_trap_en), .status_word(status_word), .trap_req(trap_req));

    function automatic logic [W-1:0] place(input logic [4:0] f);
        logic [W-1:0] w;
        w = '0;
        for (int i = 0; i < 5; i++) if (f[i]) w[POS[i]] = 1'b1;
        return w;
    endfunction

    task automatic chk_word(input string tag, input logic [W-1:0] exp);
        n_run++;
        if (status_word !== exp) begin
            n_fail++;
            $display("FAIL %s word got %h expected %h", tag, status_word, exp);
        end
    endtask

    task automatic chk_trap(input string tag, input logic exp);
        n_run++;
        if (trap_req !== exp) begin
            n_fail++;
            $display("FAIL %s trap got %b expected %b", tag, trap_req, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        commit = 0; hw_post = 0; hw_flags = '0; cur_flags = '0;
        trap_en = '0; sw_trap_en = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_live = '0; exp_saved = '0; exp_trap = 1'b0;
    endtask

    // one cycle of stimulus, model update, then sample at the next negedge
    task automatic step(input string tag, input logic c, input logic hp,
                        input logic [4:0] hw, input logic [4:0] cur,
                        input logic [4:0] en, input logic sw);
        logic [W-1:0] base;
        commit = c; hw_post = hp; hw_flags = hw; cur_flags = cur;
        trap_en = en; sw_trap_en = sw;
        base = hp ? (exp_live | place(hw)) : exp_live;
        if (c) begin
            exp_live  = (base & (~place(F_INV | F_UND) | exp_saved)) | place(cur);
            exp_saved = exp_live;
            exp_trap  = sw && (|(cur & en));
        end else begin
            exp_live = base;
        end
        @(negedge clk);
        commit = 0; hw_post = 0;
        chk_word(tag, exp_live);
        chk_trap(tag, exp_trap);
    endtask

    task automatic t_reset();
        do_reset();
        chk_word("R1", '0);
        chk_trap("R1", 1'b0);
    endtask

    task automatic t_post();
        do_reset();
        step("R2", 0, 1, F_INX | F_OVF, '0, '0, 0);
        chk_word("R2 explicit", 12'h201);
        step("R2", 0, 1, F_INV, '0, '0, 0);
        step("R2 idle", 0, 0, '0, '0, '0, 0);
        chk_word("R2 explicit", 12'hA01);
    endtask

    task automatic t_spurious_inv();
        do_reset();
        step("R3", 0, 1, F_INV, '0, '0, 0);
        step("R3", 1, 0, '0, '0, '0, 0);
        chk_word("R3 rolled back", 12'h000);
        step("R3", 0, 1, F_INV, '0, '0, 0);
        step("R3", 1, 0, '0, F_INV, '0, 0);
        chk_word("R3 confirmed", 12'h800);
    endtask

    task automatic t_spurious_und();
        do_reset();
        step("R4", 0, 1, F_UND, '0, '0, 0);
        step("R4", 1, 0, '0, '0, '0, 0);
        chk_word("R4 rolled back", 12'h000);
    endtask

    task automatic t_prior_kept();
        do_reset();
        step("R5", 1, 0, '0, F_INV | F_UND, '0, 0);
        step("R5", 1, 0, '0, '0, '0, 0);
        chk_word("R5 kept", 12'h880);
    endtask

    task automatic t_others();
        do_reset();
        step("R6", 0, 1, F_OVF | F_DZ | F_INX, '0, '0, 0);
        step("R6", 1, 0, '0, '0, '0, 0);
        chk_word("R6 kept", 12'h209);
    endtask

    task automatic t_current();
        do_reset();
        step("R7", 1, 0, '0, F_DZ, '0, 0);
        chk_word("R7", 12'h008);
        step("R7", 1, 0, '0, F_INX, '0, 0);
        chk_word("R7", 12'h208);
    endtask

    task automatic t_trap();
        do_reset();
        step("R8", 1, 0, '0, F_DZ, F_DZ, 1);
        chk_trap("R8 raised", 1'b1);
        step("R8 hold", 0, 0, '0, '0, '0, 0);
        step("R8 hold", 0, 1, F_INX, F_INX, 5'h1F, 1);
        chk_trap("R8 held", 1'b1);
        step("R8", 1, 0, '0, '0, 5'h1F, 1);
        chk_trap("R8 dropped", 1'b0);
    endtask

    task automatic t_enables();
        do_reset();
        step("R9", 1, 0, '0, F_OVF, 5'h1F & ~F_OVF, 1);
        chk_trap("R9 own enable off", 1'b0);
        step("R9", 1, 0, '0, F_OVF | F_INV, 5'h1F, 0);
        chk_trap("R9 global off", 1'b0);
        step("R9", 1, 0, '0, F_INV, F_INV, 1);
        chk_trap("R9 enabled", 1'b1);
    endtask

    task automatic t_saved_ref();
        do_reset();
        step("R10", 1, 0, '0, F_INV, '0, 0);
        step("R10", 0, 1, F_UND, '0, '0, 0);
        chk_word("R10 posted", 12'h880);
        step("R10", 1, 0, '0, '0, '0, 0);
        chk_word("R10", 12'h800);
    endtask

    task automatic t_same_cycle();
        do_reset();
        step("R11", 1, 1, F_OVF | F_INV, '0, '0, 0);
        chk_word("R11", 12'h001);
        step("R11", 1, 1, F_UND | F_DZ, F_UND, '0, 0);
        chk_word("R11", 12'h089);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_post();
        t_spurious_inv();
        t_spurious_und();
        t_prior_kept();
        t_others();
        t_current();
        t_trap();
        t_enables();
        t_saved_ref();
        t_same_cycle();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule